// File: doc/BRIEF.md
# Two-Phase Toggle Word Bridge

This block carries one parameterised data word at a time from a source clock domain to an unrelated destination clock domain. A transfer is announced by inverting a request level and completed by inverting an acknowledge level. Neither level ever goes back to an idle value, so one transfer takes one request flip plus one acknowledge flip. Only these two single-bit levels pass through synchronizer chains. The word itself sits in a hold register that does not change while a transfer is outstanding, so the destination can sample it safely as a multi-cycle path.

The source side accepts a word when `src_valid` and `src_ready` are both high at a source clock edge. The destination side raises `dst_valid` for exactly one destination cycle when the captured word appears on `dst_data`. Between strobes `dst_data` keeps the last word. The next word may be accepted in the very cycle the matching acknowledge flip is seen, so a source that holds `src_valid` high streams words back to back. The reset is active low and synchronous, and it is sampled in each domain by that domain's clock.

Top module: `tw_word_bridge`

## Requirements
- R1: After reset has been sampled low by both clocks, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A word is accepted at a source edge where `src_valid` and `src_ready` are both 1. `src_ready` is 0 in the source cycle after that edge.
- R3: A `src_valid` presented while `src_ready` is 0 is ignored. Its word never reaches `dst_data` and no extra strobe appears.
- R4: The internal hold register that feeds the destination does not change in any source cycle that follows a cycle with `src_ready` at 0.
- R5: `dst_valid` is never high in two consecutive destination cycles.
- R6: `dst_data` changes only in a cycle where `dst_valid` is 1. Otherwise it keeps the last captured word.
- R7: Every strobe carries the oldest accepted word not yet delivered, bit for bit. This covers all-ones followed by all-zeros and values that cross a carry boundary.
- R8: Each accepted word produces exactly one strobe, with no losses and no duplicates.
- R9: There is no return-to-idle phase. With `src_valid` held high, a new word is accepted at the first source edge where `src_ready` is back at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| dst_clk | input | 1 | Destination domain clock, unrelated to src_clk |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| src_valid | input | 1 | Source offers `src_data` |
| src_data | input | WIDTH | Word to be carried across |
| src_ready | output | 1 | No transfer outstanding; a word may be accepted |
| dst_valid | output | 1 | One-cycle strobe: `dst_data` holds a new word |
| dst_data | output | WIDTH | Last word captured in the destination domain |

## Verification
Two source-side events can fall in the same source cycle: the acknowledge flip that frees the bridge, and the launch of the next word. The bench provokes this by holding `src_valid` high across a whole stream, so a new word is offered in the very cycle `src_ready` returns. A queue model must then see each word exactly once and in order. The bench also drives a marker word while the bridge is busy and withdraws it in the cycle `src_ready` returns. This judges that the freeing edge is neither missed nor allowed to take the busy-time word.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
// tw_pkg: shared constants and helpers for the two-phase toggle word bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package tw_pkg;
    // Fewest synchronizer stages accepted on a level crossing.
    localparam int TW_MIN_SYNC = 2;

    // A toggle level that differs from its previous sample marks one event.
    function automatic logic tw_flip(input logic now_lvl, input logic prev_lvl);
        return now_lvl ^ prev_lvl;
    endfunction
endpackage

// File: rtl/tw_sync_chain.sv
`timescale 1ns/1ps
// tw_sync_chain: multi-flop synchronizer for one single-bit level.
// Assumes: the input is a level that holds for several destination cycles;
//          reset is synchronous to clk.
module tw_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic lvl_out
);
    import tw_pkg::*;

    localparam int N = (STAGES < TW_MIN_SYNC) ? TW_MIN_SYNC : STAGES;

    logic [N-1:0] stage_q;

    // First stage samples the foreign level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= lvl_in;
    end

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_stage
            // Each further stage gives metastability one more cycle to settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign lvl_out = stage_q[N-1];
endmodule

// File: rtl/tw_src_ctrl.sv
`timescale 1ns/1ps
// tw_src_ctrl: source side of the bridge. Latches an accepted word into the
// hold register and flips the request level; idles again once the returned
// acknowledge level matches the request level.
// Assumes: ack_lvl comes from the destination domain and is synchronized here.
module tw_src_ctrl #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_word,
    output logic             in_ready,
    input  logic             ack_lvl,
    output logic             req_lvl,
    output logic [WIDTH-1:0] hold_word
);
    logic ack_seen;
    logic req_q;
    logic [WIDTH-1:0] hold_q;

    // Bring the acknowledge level into the source domain.
    tw_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (ack_lvl),
        .lvl_out (ack_seen)
    );

    // Equal levels mean the last request has been acknowledged.
    assign in_ready = (req_q == ack_seen);

    // Accept a word: freeze it in the hold register and flip the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            hold_q <= '0;
        end else if (in_valid && in_ready) begin
            req_q  <= ~req_q;
            hold_q <= in_word;
        end
    end

    assign req_lvl   = req_q;
    assign hold_word = hold_q;
endmodule

// File: rtl/tw_dst_ctrl.sv
`timescale 1ns/1ps
// tw_dst_ctrl: destination side of the bridge. Detects each request flip,
// samples the held word, strobes it out and flips the acknowledge level.
// Assumes: hold_word is stable from the request flip until the acknowledge
//          flip reaches the source, so it is read without synchronization.
module tw_dst_ctrl #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_lvl,
    input  logic [WIDTH-1:0] hold_word,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_word,
    output logic             ack_lvl
);
    import tw_pkg::*;

    logic req_seen;
    logic req_prev_q;
    logic new_word;
    logic ack_q;
    logic valid_q;
    logic [WIDTH-1:0] word_q;

    // Bring the request level into the destination domain.
    tw_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (req_lvl),
        .lvl_out (req_seen)
    );

    // Keep the previous resolved request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_prev_q <= 1'b0;
        else        req_prev_q <= req_seen;
    end

    assign new_word = tw_flip(req_seen, req_prev_q);

    // Capture the word, strobe it for one cycle and flip the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= new_word;
            if (new_word) begin
                word_q <= hold_word;
                ack_q  <= ~ack_q;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_word  = word_q;
    assign ack_lvl   = ack_q;
endmodule

// File: rtl/tw_word_bridge.sv
`timescale 1ns/1ps
// tw_word_bridge: carries one WIDTH-bit word at a time between two unrelated
// clock domains with a two-phase toggle request/acknowledge exchange.
// Assumes: rst_n is held low long enough for both clocks to sample it.
module tw_word_bridge #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             src_clk,
    input  logic             dst_clk,
    input  logic             rst_n,
    input  logic             src_valid,
    input  logic [WIDTH-1:0] src_data,
    output logic             src_ready,
    output logic             dst_valid,
    output logic [WIDTH-1:0] dst_data
);
    logic             req_lvl;
    logic             ack_lvl;
    logic [WIDTH-1:0] hold_word;

    // Source domain: accept, hold and request.
    tw_src_ctrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (src_clk),
        .rst_n     (rst_n),
        .in_valid  (src_valid),
        .in_word   (src_data),
        .in_ready  (src_ready),
        .ack_lvl   (ack_lvl),
        .req_lvl   (req_lvl),
        .hold_word (hold_word)
    );

    // Destination domain: detect, capture and acknowledge.
    tw_dst_ctrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dst (
        .clk       (dst_clk),
        .rst_n     (rst_n),
        .req_lvl   (req_lvl),
        .hold_word (hold_word),
        .out_valid (dst_valid),
        .out_word  (dst_data),
        .ack_lvl   (ack_lvl)
    );
endmodule

// File: rtl/tw_checker.sv
`timescale 1ns/1ps
// tw_checker: protocol properties of the bridge, bound to tw_word_bridge.
// Assumes: observes ports and the hold-register net only.
module tw_checker #(
    parameter int WIDTH = 16
) (
    input logic             src_clk,
    input logic             dst_clk,
    input logic             rst_n,
    input logic             src_valid,
    input logic             src_ready,
    input logic [WIDTH-1:0] hold_word,
    input logic             dst_valid,
    input logic [WIDTH-1:0] dst_data
);
    // R1: a sampled reset leaves the source idle.
    a_r1_src_idle_after_reset: assert property (@(posedge src_clk)
        !rst_n |=> src_ready);

    // R1: a sampled reset clears the destination outputs.
    a_r1_dst_clear_after_reset: assert property (@(posedge dst_clk)
        !rst_n |=> (!dst_valid && dst_data == '0));

    // R2: an accepted word makes the source busy.
    a_r2_accept_goes_busy: assert property (@(posedge src_clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> !src_ready);

    // R4: hold register frozen while a transfer is outstanding.
    a_r4_hold_frozen: assert property (@(posedge src_clk) disable iff (!rst_n)
        $past(!src_ready) |-> $stable(hold_word));

    // R5: the strobe lasts one destination cycle.
    a_r5_single_strobe: assert property (@(posedge dst_clk) disable iff (!rst_n)
        dst_valid |=> !dst_valid);

    // R6: output word changes only with a strobe.
    a_r6_data_kept: assert property (@(posedge dst_clk) disable iff (!rst_n)
        !dst_valid |-> $stable(dst_data));
endmodule

bind tw_word_bridge tw_checker #(.WIDTH(WIDTH)) u_chk (
    .src_clk   (src_clk),
    .dst_clk   (dst_clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .hold_word (hold_word),
    .dst_valid (dst_valid),
    .dst_data  (dst_data)
);

// File: tb/tw_word_bridge_tb_top.sv
`timescale 1ns/1ps
// Bench: 100 MHz source clock, unrelated destination clock, queue model.
module tw_word_bridge_tb_top;
    localparam int W = 16;
    localparam logic [W-1:0] JUNK = 16'hDEAD;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic src_valid = 1'b0;
    logic [W-1:0] src_data = '0;
    logic src_ready;
    logic dst_valid;
    logic [W-1:0] dst_data;

    int n_checks = 0;
    int n_fail   = 0;
    int n_acc    = 0;
    int n_rcv    = 0;
    bit done     = 1'b0;
    bit mon_on   = 1'b0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_word = '0;
    bit prev_valid = 1'b0;

    always #5    src_clk = ~src_clk;
    always #8.35 dst_clk = ~dst_clk;

    tw_word_bridge #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
        .src_clk   (src_clk),
        .dst_clk   (dst_clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .dst_valid (dst_valid),
        .dst_data  (dst_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Offer a word (called at a source negedge); returns one cycle after acceptance.
    task automatic push_word(input logic [W-1:0] w);
        src_valid = 1'b1;
        src_data  = w;
        while (!src_ready) @(negedge src_clk);
        exp_q.push_back(w);
        n_acc++;
        @(negedge src_clk);
        chk(!src_ready, "R2 busy after accept", {31'd0, src_ready}, 32'd0);
    endtask

    // While busy, offer the marker word; withdraw it the cycle ready returns (R3).
    task automatic busy_poke();
        forever begin
            if (src_ready) begin
                src_valid = 1'b0;
                break;
            end
            src_valid = 1'b1;
            src_data  = JUNK;
            @(negedge src_clk);
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] v = W'($urandom);
        if (v == JUNK) v = ~v;
        return v;
    endfunction

    // Destination model: compared on every destination cycle.
    always @(negedge dst_clk) begin
        if (mon_on) begin
            if (dst_valid) begin
                chk(!prev_valid, "R5 strobe one cycle", 32'd1, 32'd0);
                chk(dst_data != JUNK, "R3 busy word leaked", 32'(dst_data), 32'(JUNK));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 strobe with nothing accepted", 32'(dst_data), 32'd0);
                end else begin
                    chk(dst_data == exp_q[0], "R7 word order/value", 32'(dst_data), 32'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
                last_word = dst_data;
                n_rcv++;
            end else begin
                chk(dst_data == last_word, "R6 word kept", 32'(dst_data), 32'(last_word));
            end
            prev_valid = dst_valid;
        end
    end

    initial begin
        repeat (150000) @(posedge src_clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [W-1:0] edges[6];
        int t0;
        repeat (6) @(posedge dst_clk);
        @(negedge src_clk);
        // R1: reset state sampled by both clocks
        chk(src_ready == 1'b1, "R1 ready in reset", {31'd0, src_ready}, 32'd1);
        chk(dst_valid == 1'b0, "R1 no strobe in reset", {31'd0, dst_valid}, 32'd0);
        chk(dst_data == '0, "R1 data zero in reset", 32'(dst_data), 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3) @(negedge src_clk);

        // R7: all ones then all zeros, isolated.
        push_word('1);
        src_valid = 1'b0;
        repeat (20) @(negedge src_clk);
        push_word('0);
        src_valid = 1'b0;
        repeat (20) @(negedge src_clk);

        // R7: carry-boundary values, sent back to back (R9).
        edges = '{16'h00FF, 16'h0100, 16'h7FFF, 16'h8000, 16'h3FFF, 16'h4000};
        foreach (edges[i]) push_word(edges[i]);
        src_valid = 1'b0;

        // R3: marker word offered while busy, withdrawn as ready returns.
        for (int k = 0; k < 6; k++) begin
            push_word(rnd_word());
            busy_poke();
            @(negedge src_clk);
        end

        // R9: long back-to-back random stream with valid held high.
        for (int k = 0; k < 40; k++) push_word(rnd_word());
        src_valid = 1'b0;

        // Drain and check completeness.
        t0 = 0;
        while ((exp_q.size() != 0) && (t0 < 2000)) begin
            @(negedge src_clk);
            t0++;
        end
        repeat (20) @(negedge dst_clk);
        chk(exp_q.size() == 0, "R8 all words delivered", 32'(exp_q.size()), 32'd0);
        chk(n_rcv == n_acc, "R8 one strobe per word", 32'(n_rcv), 32'(n_acc));
        chk(src_ready == 1'b1, "R9 idle after stream", {31'd0, src_ready}, 32'd1);
        finish_run();
    end
endmodule